// File: doc/BRIEF.md
# Debug Event Matcher

This block decides whether an access raises a debug event. It holds no registers of its own. Instead it looks at a bank of breakpoint control words and a bank of watchpoint control words, both supplied from outside, and checks each one against the current access context. A separate comparator has already matched the address and reports the result per entry as a hit bit. This block then qualifies every hit by security state and privilege level. Where an entry asks for it, the hit is also qualified by a linked context-ID comparator taken from the breakpoint bank.

A query is a single-cycle strobe on `q_valid`. `q_watch` selects which bank is evaluated. One clock later the block gives a one-cycle `res_valid` pulse together with the match flag and the index of the lowest-numbered qualifying entry. The result side has no back-pressure: the consumer must take the result in the cycle it is offered. A new query may be issued on every clock. Both banks are evaluated in parallel, and the final result register is the only pipeline stage.

Control word layout, shared by both banks:
- bit 0: enable
- bits 2:1: privilege field
- bit 13: higher-level bit
- bits 15:14: security field
- bits 19:16: linked entry number
- bit 20: link enable
- bits 23:20: when a breakpoint is used as a link target, these bits read as its type

Top module: `dbg_event_match`

## Requirements
- R1: When `mon_en` is 0 or `dbg_masked` is 1 during a query, the result reports no match (`res_match`=0, `res_idx`=0), whatever the entries hold.
- R2: An entry can match only if its enable bit (bit 0) is 1 and its hit bit is 1.
- R3: Security field (bits 15:14). The value 0 accepts both security states. The values 1 and 3 reject the entry when `secure`=1. The value 2 rejects the entry when `secure`=0.
- R4: Privilege check at the effective level. At level 2 or 3 the higher-level bit (bit 13) must be 1. At level 1 privilege bit 1 (control bit 1) must be 1. At level 0 privilege bit 2 (control bit 2) must be 1.
- R5: For a watchpoint query with `unpriv`=1, the effective level is 0 whatever `cur_el` is. Breakpoint queries always use `cur_el` and ignore `unpriv`.
- R6: When the link enable bit (bit 20) is 1, the entry matches only if its linked entry number (bits 19:16) lies in the range NUM_BP-NUM_CTX to NUM_BP-1. Any other number blocks the match.
- R7: The linked breakpoint must have its enable bit set and its type field (bits 23:20) equal to 3. Any other type blocks the match.
- R8: A linked context check passes only if `cur_el` is 0 or 1 and `ctx_id` equals the linked breakpoint's 32-bit `bp_ctx` value.
- R9: When several entries of the selected bank qualify, `res_idx` gives the lowest index. When none qualifies, `res_match`=0 and `res_idx`=0.
- R10: `res_valid` is 1 exactly in the cycle after a cycle with `q_valid`=1. Without a query, `res_match` and `res_idx` are 0.
- R11: After reset, `res_valid`, `res_match` and `res_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Query strobe |
| q_watch | input | 1 | 1 = evaluate watchpoint bank, 0 = breakpoint bank |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Current security state is secure |
| unpriv | input | 1 | Access is an unprivileged load/store |
| mon_en | input | 1 | Global monitor-debug enable |
| dbg_masked | input | 1 | Debug exceptions currently masked |
| ctx_id | input | 32 | Current context ID |
| bp_ctrl | input | NUM_BP*24 | Breakpoint control words |
| bp_ctx | input | NUM_BP*32 | Breakpoint value words (context values) |
| bp_hit | input | NUM_BP | Breakpoint address-hit flags |
| wp_ctrl | input | NUM_WP*24 | Watchpoint control words |
| wp_hit | input | NUM_WP | Watchpoint address-hit flags |
| res_valid | output | 1 | Result valid pulse |
| res_match | output | 1 | A debug event fires |
| res_idx | output | IDX_W | Index of the matching entry |

## Verification
The bench builds the block with its defaults: NUM_BP=6, NUM_CTX=2 and NUM_WP=4. With these values entries 4 and 5 are the context-capable link targets. Entry 3 lies just below that window, and numbers 6 to 15 lie above the implemented count, so both sides of the link range check can be reached with a 4-bit link field. Random queries draw link numbers, context values and type fields from small sets so that chained context matches and multi-hit priority cases occur often. Directed cases cover each security, level and link corner.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  localparam int CTRL_W    = 24;
  localparam int CTX_W     = 32;
  localparam int B_EN      = 0;
  localparam int B_PRIV_LO = 1;
  localparam int B_PRIV_HI = 2;
  localparam int B_HMODE   = 13;
  localparam int B_SEC_LO  = 14;
  localparam int B_SEC_HI  = 15;
  localparam int B_LNK_LO  = 16;
  localparam int B_LNK_HI  = 19;
  localparam int B_LINK    = 20;
  localparam int B_TYP_LO  = 20;
  localparam int B_TYP_HI  = 23;
  localparam logic [3:0] TYPE_CTX = 4'd3;
endpackage

// File: rtl/dbgm_link_chk.sv
module dbgm_link_chk
  import dbgm_pkg::*;
#(
  parameter int NUM_BP  = 6,
  parameter int NUM_CTX = 2
) (
  input  logic [3:0]                          lbn,
  input  logic [NUM_BP-1:0][CTRL_W-1:0]       bp_ctrl,
  input  logic [NUM_BP-1:0][CTX_W-1:0]        bp_ctx,
  input  logic [1:0]                          cur_el,
  input  logic [CTX_W-1:0]                    ctx_id,
  output logic                                ok
);
  localparam int FIRST_CTX = NUM_BP - NUM_CTX;

  logic              in_range;
  logic [CTRL_W-1:0] sel_ctrl;
  logic [CTX_W-1:0]  sel_ctx;
  logic              unused_bits;

  always_comb begin
    sel_ctrl = '0;
    sel_ctx  = '0;
    for (int i = 0; i < NUM_BP; i++) begin
      if (int'(lbn) == i) begin
        sel_ctrl = bp_ctrl[i];
        sel_ctx  = bp_ctx[i];
      end
    end
  end

  assign in_range = (int'(lbn) >= FIRST_CTX) && (int'(lbn) <= NUM_BP - 1);

  assign ok = in_range
            && sel_ctrl[B_EN]
            && (sel_ctrl[B_TYP_HI:B_TYP_LO] == TYPE_CTX)
            && (cur_el <= 2'd1)
            && (sel_ctx == ctx_id);

  assign unused_bits = ^sel_ctrl[B_TYP_LO-1:B_EN+1];
endmodule

// File: rtl/dbgm_entry_qual.sv
module dbgm_entry_qual
  import dbgm_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              hit,
  input  logic              secure,
  input  logic [1:0]        ael,
  input  logic              link_ok,
  output logic              fire
);
  logic [1:0] sec_f;
  logic [1:0] priv_f;
  logic       sec_ok;
  logic       lvl_ok;
  logic       unused_bits;

  assign sec_f  = ctrl[B_SEC_HI:B_SEC_LO];
  assign priv_f = ctrl[B_PRIV_HI:B_PRIV_LO];

  always_comb begin
    unique case (sec_f)
      2'd0:    sec_ok = 1'b1;
      2'd2:    sec_ok = secure;
      default: sec_ok = !secure;
    endcase
  end

  always_comb begin
    unique case (ael)
      2'd0:    lvl_ok = priv_f[1];
      2'd1:    lvl_ok = priv_f[0];
      default: lvl_ok = ctrl[B_HMODE];
    endcase
  end

  assign fire = ctrl[B_EN] && hit && sec_ok && lvl_ok
              && (!ctrl[B_LINK] || link_ok);

  assign unused_bits = ^{ctrl[B_TYP_HI:B_LINK+1], ctrl[B_HMODE-1:B_PRIV_HI+1],
                         ctrl[B_LNK_HI:B_LNK_LO]};
endmodule

// File: rtl/dbgm_pick.sv
module dbgm_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dbg_event_match.sv
module dbg_event_match
  import dbgm_pkg::*;
#(
  parameter int NUM_BP  = 6,
  parameter int NUM_CTX = 2,
  parameter int NUM_WP  = 4,
  localparam int MAXN   = (NUM_BP > NUM_WP) ? NUM_BP : NUM_WP,
  localparam int IDX_W  = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          q_valid,
  input  logic                          q_watch,
  input  logic [1:0]                    cur_el,
  input  logic                          secure,
  input  logic                          unpriv,
  input  logic                          mon_en,
  input  logic                          dbg_masked,
  input  logic [CTX_W-1:0]              ctx_id,
  input  logic [NUM_BP-1:0][CTRL_W-1:0] bp_ctrl,
  input  logic [NUM_BP-1:0][CTX_W-1:0]  bp_ctx,
  input  logic [NUM_BP-1:0]             bp_hit,
  input  logic [NUM_WP-1:0][CTRL_W-1:0] wp_ctrl,
  input  logic [NUM_WP-1:0]             wp_hit,
  output logic                          res_valid,
  output logic                          res_match,
  output logic [IDX_W-1:0]              res_idx
);
  logic [NUM_BP-1:0] bp_link_ok, bp_fire;
  logic [NUM_WP-1:0] wp_link_ok, wp_fire;
  logic [1:0]        wp_ael;
  logic              bp_any, wp_any, sel_any, gate_ok;
  logic [IDX_W-1:0]  bp_idx, wp_idx, sel_idx;

  assign wp_ael  = unpriv ? 2'd0 : cur_el;
  assign gate_ok = mon_en && !dbg_masked;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    dbgm_link_chk #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_link (
      .lbn     (bp_ctrl[i][B_LNK_HI:B_LNK_LO]),
      .bp_ctrl (bp_ctrl),
      .bp_ctx  (bp_ctx),
      .cur_el  (cur_el),
      .ctx_id  (ctx_id),
      .ok      (bp_link_ok[i])
    );
    dbgm_entry_qual u_qual (
      .ctrl    (bp_ctrl[i]),
      .hit     (bp_hit[i]),
      .secure  (secure),
      .ael     (cur_el),
      .link_ok (bp_link_ok[i]),
      .fire    (bp_fire[i])
    );
  end

  for (genvar j = 0; j < NUM_WP; j++) begin : g_wp
    dbgm_link_chk #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX)) u_link (
      .lbn     (wp_ctrl[j][B_LNK_HI:B_LNK_LO]),
      .bp_ctrl (bp_ctrl),
      .bp_ctx  (bp_ctx),
      .cur_el  (cur_el),
      .ctx_id  (ctx_id),
      .ok      (wp_link_ok[j])
    );
    dbgm_entry_qual u_qual (
      .ctrl    (wp_ctrl[j]),
      .hit     (wp_hit[j]),
      .secure  (secure),
      .ael     (wp_ael),
      .link_ok (wp_link_ok[j]),
      .fire    (wp_fire[j])
    );
  end

  dbgm_pick #(.N(NUM_BP), .IW(IDX_W)) u_pick_bp (
    .req (bp_fire), .any (bp_any), .idx (bp_idx)
  );
  dbgm_pick #(.N(NUM_WP), .IW(IDX_W)) u_pick_wp (
    .req (wp_fire), .any (wp_any), .idx (wp_idx)
  );

  assign sel_any = gate_ok && (q_watch ? wp_any : bp_any);
  assign sel_idx = sel_any ? (q_watch ? wp_idx : bp_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_match <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= q_valid;
      res_match <= q_valid && sel_any;
      res_idx   <= q_valid ? sel_idx : '0;
    end
  end
endmodule

// File: rtl/dbgm_chk.sv
module dbgm_chk #(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 4,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              q_valid,
  input logic              q_watch,
  input logic              mon_en,
  input logic              dbg_masked,
  input logic [NUM_BP-1:0] bp_hit,
  input logic [NUM_WP-1:0] wp_hit,
  input logic              res_valid,
  input logic              res_match,
  input logic [IDX_W-1:0]  res_idx
);
  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> res_valid);
  // R10
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !res_valid);
  // R1
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && (!mon_en || dbg_masked)) |=> !res_match);
  // R2
  no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && ((!q_watch && bp_hit == '0) || (q_watch && wp_hit == '0)))
      |=> !res_match);
  // R9
  idx_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_match |-> (res_idx == '0));
  // R10
  match_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_match |-> res_valid);
endmodule

bind dbg_event_match dbgm_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_valid    (q_valid),
  .q_watch    (q_watch),
  .mon_en     (mon_en),
  .dbg_masked (dbg_masked),
  .bp_hit     (bp_hit),
  .wp_hit     (wp_hit),
  .res_valid  (res_valid),
  .res_match  (res_match),
  .res_idx    (res_idx)
);

// File: tb/dbg_event_match_test.sv
`timescale 1ns/1ps
module dbg_event_match_test;
  localparam int NBP = 6;
  localparam int NCX = 2;
  localparam int NWP = 4;
  localparam int IW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_valid = 1'b0, q_watch = 1'b0;
  logic [1:0] cur_el = 2'd1;
  logic secure = 1'b0, unpriv = 1'b0, mon_en = 1'b1, dbg_masked = 1'b0;
  logic [31:0] ctx_id = '0;
  logic [NBP-1:0][23:0] bp_ctrl = '0;
  logic [NBP-1:0][31:0] bp_ctx = '0;
  logic [NBP-1:0] bp_hit = '0;
  logic [NWP-1:0][23:0] wp_ctrl = '0;
  logic [NWP-1:0] wp_hit = '0;
  logic res_valid, res_match;
  logic [IW-1:0] res_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dbg_event_match uut (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_watch(q_watch),
    .cur_el(cur_el), .secure(secure), .unpriv(unpriv), .mon_en(mon_en),
    .dbg_masked(dbg_masked), .ctx_id(ctx_id), .bp_ctrl(bp_ctrl),
    .bp_ctx(bp_ctx), .bp_hit(bp_hit), .wp_ctrl(wp_ctrl), .wp_hit(wp_hit),
    .res_valid(res_valid), .res_match(res_match), .res_idx(res_idx)
  );

  function automatic logic [23:0] mk(input bit en, input bit [1:0] pv,
      input bit hm, input bit [1:0] sc, input bit [3:0] ln, input bit [3:0] hi);
    logic [23:0] c;
    c = '0;
    c[0] = en; c[2:1] = pv; c[13] = hm; c[15:14] = sc;
    c[19:16] = ln; c[23:20] = hi;
    return c;
  endfunction

  function automatic bit ref_link(input logic [3:0] ln);
    if (int'(ln) > NBP - 1 || int'(ln) < NBP - NCX) return 1'b0;
    if (!bp_ctrl[ln][0]) return 1'b0;
    if (bp_ctrl[ln][23:20] != 4'd3) return 1'b0;
    if (cur_el > 2'd1) return 1'b0;
    return ctx_id == bp_ctx[ln];
  endfunction

  function automatic bit ref_entry(input logic [23:0] c, input bit h, input bit w);
    logic [1:0] lv;
    bit ok;
    lv = (w && unpriv) ? 2'd0 : cur_el;
    if (!c[0] || !h) return 1'b0;
    case (c[15:14])
      2'd0: ok = 1'b1;
      2'd2: ok = secure;
      default: ok = !secure;
    endcase
    if (!ok) return 1'b0;
    if (lv >= 2'd2) ok = c[13];
    else if (lv == 2'd1) ok = c[1];
    else ok = c[2];
    if (!ok) return 1'b0;
    if (c[20] && !ref_link(c[19:16])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic ref_model(input bit w, output bit m, output logic [IW-1:0] ix);
    m = 1'b0; ix = '0;
    if (!mon_en || dbg_masked) return;
    if (w) begin
      for (int i = 0; i < NWP; i++)
        if (!m && ref_entry(wp_ctrl[i], wp_hit[i], 1'b1)) begin m = 1'b1; ix = IW'(i); end
    end else begin
      for (int i = 0; i < NBP; i++)
        if (!m && ref_entry(bp_ctrl[i], bp_hit[i], 1'b0)) begin m = 1'b1; ix = IW'(i); end
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic query(input bit w, input string req);
    bit em;
    logic [IW-1:0] ei;
    ref_model(w, em, ei);
    q_watch = w;
    q_valid = 1'b1;
    @(posedge clk);
    #1 q_valid = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b1, {req, " valid"}, int'(res_valid), 1);
    chk(res_match == em, {req, " match"}, int'(res_match), int'(em));
    chk(res_idx == ei, {req, " index"}, int'(res_idx), int'(ei));
  endtask

  task automatic clear_all();
    bp_ctrl = '0; bp_ctx = '0; bp_hit = '0; wp_ctrl = '0; wp_hit = '0;
    mon_en = 1'b1; dbg_masked = 1'b0; secure = 1'b0; unpriv = 1'b0;
    cur_el = 2'd1; ctx_id = 32'h0;
  endtask

  task automatic expect_bp(input bit m, input int ix, input string req);
    bit em;
    logic [IW-1:0] ei;
    ref_model(1'b0, em, ei);
    chk(em == m && int'(ei) == ix, {req, " directed model"}, int'(em), int'(m));
    query(1'b0, req);
  endtask

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(res_valid == 0 && res_match == 0 && res_idx == 0, "R11 reset", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 0 && res_match == 0 && res_idx == 0, "R11 after reset", int'(res_match), 0);

    // R1 global gating
    clear_all();
    bp_ctrl[0] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0); bp_hit[0] = 1;
    mon_en = 0;     expect_bp(0, 0, "R1 monitor off");
    mon_en = 1; dbg_masked = 1; expect_bp(0, 0, "R1 masked");
    dbg_masked = 0; expect_bp(1, 0, "R1 enabled");

    // R2 enable and hit
    bp_ctrl[0][0] = 0; expect_bp(0, 0, "R2 disabled entry");
    bp_ctrl[0][0] = 1; bp_hit[0] = 0; expect_bp(0, 0, "R2 no hit");
    bp_hit[0] = 1;

    // R3 security field
    bp_ctrl[0][15:14] = 2'd1; secure = 1; expect_bp(0, 0, "R3 sec1 secure");
    bp_ctrl[0][15:14] = 2'd3; secure = 0; expect_bp(1, 0, "R3 sec3 nonsecure");
    bp_ctrl[0][15:14] = 2'd2; expect_bp(0, 0, "R3 sec2 nonsecure");
    secure = 1; expect_bp(1, 0, "R3 sec2 secure");
    bp_ctrl[0][15:14] = 2'd0; secure = 0;

    // R4 levels
    cur_el = 2; bp_ctrl[0][13] = 0; expect_bp(0, 0, "R4 el2 no hmode");
    cur_el = 3; bp_ctrl[0][13] = 1; bp_ctrl[0][2:1] = 2'b00; expect_bp(1, 0, "R4 el3 hmode");
    cur_el = 1; bp_ctrl[0][2:1] = 2'b10; expect_bp(0, 0, "R4 el1 wrong bit");
    bp_ctrl[0][2:1] = 2'b01; expect_bp(1, 0, "R4 el1 ok");
    cur_el = 0; expect_bp(0, 0, "R4 el0 wrong bit");
    bp_ctrl[0][2:1] = 2'b10; expect_bp(1, 0, "R4 el0 ok");

    // R5 unprivileged access
    clear_all();
    cur_el = 1; unpriv = 1;
    wp_ctrl[2] = mk(1, 2'b10, 0, 2'd0, 4'd0, 4'd0); wp_hit[2] = 1;
    query(1'b1, "R5 watch unpriv at el0");
    chk(res_match == 1 && res_idx == 2, "R5 watch idx2", int'(res_idx), 2);
    wp_ctrl[2][2:1] = 2'b01;
    query(1'b1, "R5 watch unpriv rejects el1 bit");
    chk(res_match == 0, "R5 watch no match", int'(res_match), 0);
    bp_ctrl[1] = mk(1, 2'b01, 0, 2'd0, 4'd0, 4'd0); bp_hit[1] = 1;
    expect_bp(1, 1, "R5 breakpoint ignores unpriv");

    // R6/R7/R8 linking
    clear_all();
    ctx_id = 32'hCAFE_0001;
    bp_ctrl[3] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd3); bp_ctx[3] = 32'hCAFE_0001;
    bp_ctrl[5] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd3); bp_ctx[5] = 32'hCAFE_0001;
    bp_ctrl[0] = mk(1, 2'b11, 1, 2'd0, 4'd3, 4'd1); bp_hit[0] = 1;
    expect_bp(0, 0, "R6 link below range");
    bp_ctrl[0][19:16] = 4'd5; expect_bp(1, 0, "R6 link in range");
    bp_ctrl[0][19:16] = 4'd7; expect_bp(0, 0, "R6 link above range");
    bp_ctrl[0][19:16] = 4'd5;
    bp_ctrl[5][0] = 0; expect_bp(0, 0, "R7 link target disabled");
    bp_ctrl[5][0] = 1; bp_ctrl[5][23:20] = 4'd5; expect_bp(0, 0, "R7 link type 5");
    bp_ctrl[5][23:20] = 4'd3;
    cur_el = 2; expect_bp(0, 0, "R8 link at el2");
    cur_el = 0; ctx_id = 32'hCAFE_0002; expect_bp(0, 0, "R8 ctx mismatch");
    ctx_id = 32'hCAFE_0001; expect_bp(1, 0, "R8 ctx equal el0");

    // R9 priority
    clear_all();
    bp_ctrl[1] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0); bp_hit[1] = 1;
    bp_ctrl[3] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0); bp_hit[3] = 1;
    expect_bp(1, 1, "R9 lowest of two");
    wp_ctrl[3] = mk(1, 2'b11, 1, 2'd0, 4'd0, 4'd0); wp_hit[3] = 1;
    query(1'b1, "R9 watch bank");
    chk(res_idx == 3, "R9 watch idx3", int'(res_idx), 3);

    // R10 idle cycle
    @(posedge clk); @(negedge clk);
    chk(res_valid == 0 && res_match == 0 && res_idx == 0, "R10 idle", int'(res_valid), 0);

    // random mix, all requirements R1-style coverage through the model
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NBP; i++) begin
        bp_ctrl[i] = 24'($urandom);
        bp_ctrl[i][0] = ($urandom % 8) != 0;
        if ($urandom % 2) bp_ctrl[i][19:16] = 4'(NBP - NCX + ($urandom % NCX));
        if ($urandom % 2) bp_ctrl[i][23:20] = 4'd3;
        bp_ctx[i] = 32'h100 + ($urandom % 2);
      end
      for (int j = 0; j < NWP; j++) begin
        wp_ctrl[j] = 24'($urandom);
        wp_ctrl[j][0] = ($urandom % 8) != 0;
        if ($urandom % 2) wp_ctrl[j][19:16] = 4'(NBP - NCX + ($urandom % NCX));
      end
      bp_hit = NBP'($urandom); wp_hit = NWP'($urandom);
      cur_el = 2'($urandom); secure = 1'($urandom); unpriv = 1'($urandom);
      mon_en = ($urandom % 10) != 0; dbg_masked = ($urandom % 10) == 0;
      ctx_id = 32'h100 + ($urandom % 2);
      query(1'($urandom), "R9 random");
      if (n % 16 == 0) begin
        @(posedge clk); @(negedge clk);
        chk(res_valid == 0 && res_match == 0, "R10 random idle", int'(res_valid), 0);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule